// File: doc/BRIEF.md
# External Chip-Select Region Decoder

This block turns a 32-bit internal address into a selection of one of several external static-memory regions. Each region has a base address, a power-of-two page size, an enable bit and a bus-width flag. Software sets these through a small APB-style register port. For every access presented to it, the block drives exactly one active-low chip enable. It also produces the external address, which is the offset inside the matched page with the byte-lane bits the chosen bus width does not use cleared to zero. Because only the offset bits reach the device, a device smaller than its page appears repeated across the whole page.

When no enabled region claims the address, no chip enable is driven and an abort is raised instead. The abort is typed as an instruction-fetch abort or a data abort, and carries the exception vector for that type. When the internal-boot input is high, an internal ROM owns address zero, so any region whose aligned base is zero is ignored. Results are registered: they appear one clock after the access is presented.

Top module: `xrd_top`

## Requirements
- R1: After reset, region 0 reads back as 0x000000C1: enabled, base 0, size code 12, 16-bit bus. Every other region reads back 0. No chip enable is low and abort is low.
- R2: Region i is the 32-bit word at byte offset 4*i. The fields are base in [31:12], size code in [7:4], wide flag (1 = 32-bit bus) in [1] and enable in [0]. A write is committed only on a clock where reg_sel, reg_enable and reg_write are all high. Readback returns the stored fields, with all other bits zero.
- R3: A region with size code k has a page of 2^(12+k) bytes. An address matches the region when its bits at and above position 12+k equal the same bits of the base. Base bits below the page size are ignored.
- R4: One clock after a valid access, the chip enable of the selected region is low and all others are high. At most one chip enable is ever low.
- R5: When several enabled regions match, the lowest-numbered one is selected.
- R6: ext_addr is the address offset within the selected page. bits [1:0] are cleared for a 32-bit region, and bit [0] is cleared for a 16-bit region. bus_wide shows the selected region's width. Addresses anywhere in the page select the region.
- R7: A valid access that matches no enabled region leaves all chip enables high and raises abort. abort_fetch equals acc_is_fetch, and abort_vector is 0x0000000C for a fetch and 0x00000010 for data.
- R8: While boot_internal is high, a region whose aligned base is zero never matches. Other regions are unaffected.
- R9: One clock after a cycle with acc_valid low, all chip enables are high, abort is low and ext_addr is zero.
- R10: A region with its enable bit clear is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register port select |
| reg_enable | input | 1 | Register port access phase |
| reg_write | input | 1 | Register port write (1) or read (0) |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| boot_internal | input | 1 | Internal ROM owns address zero |
| acc_valid | input | 1 | Access request this cycle |
| acc_addr | input | 32 | Internal access address |
| acc_is_fetch | input | 1 | Access is an instruction fetch |
| ce_n | output | 4 | Active-low chip enables, one per region |
| ext_addr | output | 24 | External address |
| bus_wide | output | 1 | Selected region uses a 32-bit bus |
| abort | output | 1 | Access matched no region |
| abort_fetch | output | 1 | Abort was for an instruction fetch |
| abort_vector | output | 32 | Exception vector of the abort |

## Verification
The bench builds the block with its defaults: four regions and a 24-bit external bus. With those values the largest page, 16 MB, spans the whole external address, and the smallest, 4 KB, is reachable too. Four regions are enough to configure overlapping pages for the priority rule and to keep one region disabled while it shares no address with the others. Both page extremes and the bit-clearing for both widths are exercised. Both abort types are exercised, as is the boot override of the region at zero.

// File: rtl/xrd_pkg.sv
package xrd_pkg;
  localparam int ADDR_W   = 32;
  localparam int MIN_PG   = 12;
  localparam int BASE_W   = ADDR_W - MIN_PG;
  localparam int CODE_W   = 4;

  localparam logic [ADDR_W-1:0] FETCH_VEC = 32'h0000_000C;
  localparam logic [ADDR_W-1:0] DATA_VEC  = 32'h0000_0010;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] size_code;
    logic              wide;
    logic              en;
  } region_cfg_t;
endpackage

// File: rtl/xrd_regfile.sv
module xrd_regfile
  import xrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int EXT_W  = 24,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int RAW   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [RAW-1:0]    addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output region_cfg_t       cfg [NUM_CS]
);
  localparam int MAX_CODE = EXT_W - MIN_PG;

  logic [IDX_W-1:0] idx;
  logic             fire;
  region_cfg_t      wr_val;
  logic             unused_bits;

  assign idx  = addr[RAW-1:2];
  assign fire = sel && enable && write;
  assign unused_bits = ^{wdata[11:8], wdata[3:2], addr[1:0]};

  always_comb begin
    wr_val.base      = wdata[ADDR_W-1:MIN_PG];
    wr_val.size_code = wdata[7:4];
    wr_val.wide      = wdata[1];
    wr_val.en        = wdata[0];
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
    region_cfg_t rst_val;
    region_cfg_t cfg_q;
    region_cfg_t cfg_d;
    logic        we;

    always_comb begin
      rst_val = '0;
      if (i == 0) begin
        rst_val.size_code = CODE_W'(MAX_CODE);
        rst_val.en        = 1'b1;
      end
    end

    assign we    = fire && (int'(idx) == i);
    assign cfg_d = we ? wr_val : cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= rst_val;
      else if (we) cfg_q <= cfg_d;
    end

    assign cfg[i] = cfg_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (int'(idx) == i)
        rdata = {cfg[i].base, 4'b0, cfg[i].size_code, 2'b0, cfg[i].wide, cfg[i].en};
    end
  end
endmodule

// File: rtl/xrd_region_match.sv
module xrd_region_match
  import xrd_pkg::*;
#(
  parameter int EXT_W = 24
) (
  input  region_cfg_t       cfg,
  input  logic              boot_internal,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [EXT_W-1:0]  offset
);
  localparam int MAX_CODE = EXT_W - MIN_PG;

  logic [CODE_W-1:0] code_eff;
  logic [5:0]        pg_log2;
  logic [ADDR_W-1:0] hi_mask;
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] base_aligned;
  logic [ADDR_W-1:0] off_full;
  logic              boot_block;
  logic              unused_hi;

  always_comb begin
    code_eff     = (int'(cfg.size_code) > MAX_CODE) ? CODE_W'(MAX_CODE) : cfg.size_code;
    pg_log2      = 6'(MIN_PG) + 6'(code_eff);
    hi_mask      = ~((ADDR_W'(1) << pg_log2) - ADDR_W'(1));
    base_full    = {cfg.base, {MIN_PG{1'b0}}};
    base_aligned = base_full & hi_mask;
    boot_block   = boot_internal && (base_aligned == '0);
    hit          = cfg.en && !boot_block && ((addr & hi_mask) == base_aligned);
    off_full     = addr & ~hi_mask;
  end

  assign offset    = off_full[EXT_W-1:0];
  assign unused_hi = ^off_full[ADDR_W-1:EXT_W];
endmodule

// File: rtl/xrd_pick.sv
module xrd_pick #(
  parameter int NUM_CS = 4,
  parameter int EXT_W  = 24
) (
  input  logic [NUM_CS-1:0] hit,
  input  logic [EXT_W-1:0]  offset [NUM_CS],
  input  logic [NUM_CS-1:0] wide,
  output logic              any_hit,
  output logic [NUM_CS-1:0] onehot,
  output logic [EXT_W-1:0]  sel_offset,
  output logic              sel_wide
);
  always_comb begin
    onehot     = '0;
    sel_offset = '0;
    sel_wide   = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        onehot     = '0;
        onehot[i]  = 1'b1;
        sel_offset = offset[i];
        sel_wide   = wide[i];
      end
    end
    any_hit = |hit;
  end
endmodule

// File: rtl/xrd_top.sv
module xrd_top
  import xrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int EXT_W  = 24,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int RAW   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_enable,
  input  logic              reg_write,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              boot_internal,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_is_fetch,
  output logic [NUM_CS-1:0] ce_n,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              bus_wide,
  output logic              abort,
  output logic              abort_fetch,
  output logic [31:0]       abort_vector
);
  region_cfg_t       cfg [NUM_CS];
  logic [NUM_CS-1:0] hit;
  logic [NUM_CS-1:0] wide;
  logic [EXT_W-1:0]  offset [NUM_CS];
  logic              any_hit;
  logic [NUM_CS-1:0] onehot;
  logic [EXT_W-1:0]  sel_offset;
  logic              sel_wide;

  logic [NUM_CS-1:0] ce_n_d;
  logic [EXT_W-1:0]  ext_d;
  logic              wide_d, abort_d, fetch_d;
  logic [31:0]       vec_d;

  xrd_regfile #(.NUM_CS(NUM_CS), .EXT_W(EXT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (reg_sel),
    .enable (reg_enable),
    .write  (reg_write),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .cfg    (cfg)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_match
    xrd_region_match #(.EXT_W(EXT_W)) u_match (
      .cfg           (cfg[i]),
      .boot_internal (boot_internal),
      .addr          (acc_addr),
      .hit           (hit[i]),
      .offset        (offset[i])
    );
    assign wide[i] = cfg[i].wide;
  end

  xrd_pick #(.NUM_CS(NUM_CS), .EXT_W(EXT_W)) u_pick (
    .hit        (hit),
    .offset     (offset),
    .wide       (wide),
    .any_hit    (any_hit),
    .onehot     (onehot),
    .sel_offset (sel_offset),
    .sel_wide   (sel_wide)
  );

  // next-state
  always_comb begin
    ce_n_d  = '1;
    ext_d   = '0;
    wide_d  = 1'b0;
    abort_d = 1'b0;
    fetch_d = 1'b0;
    vec_d   = '0;
    if (acc_valid) begin
      if (any_hit) begin
        ce_n_d = ~onehot;
        wide_d = sel_wide;
        ext_d  = sel_offset;
        if (sel_wide) ext_d[1:0] = 2'b00;
        else          ext_d[0]   = 1'b0;
      end else begin
        abort_d = 1'b1;
        fetch_d = acc_is_fetch;
        vec_d   = acc_is_fetch ? FETCH_VEC : DATA_VEC;
      end
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n         <= '1;
      ext_addr     <= '0;
      bus_wide     <= 1'b0;
      abort        <= 1'b0;
      abort_fetch  <= 1'b0;
      abort_vector <= '0;
    end else begin
      ce_n         <= ce_n_d;
      ext_addr     <= ext_d;
      bus_wide     <= wide_d;
      abort        <= abort_d;
      abort_fetch  <= fetch_d;
      abort_vector <= vec_d;
    end
  end
endmodule

// File: rtl/xrd_checks.sv
module xrd_checks #(
  parameter int NUM_CS = 4,
  parameter int EXT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_is_fetch,
  input logic [NUM_CS-1:0] ce_n,
  input logic [EXT_W-1:0]  ext_addr,
  input logic              bus_wide,
  input logic              abort,
  input logic              abort_fetch,
  input logic [31:0]       abort_vector
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r4_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));

  a_r7_abort_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (&ce_n));

  a_r7_fetch_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && abort && $past(acc_is_fetch)) |-> (abort_fetch && abort_vector == 32'h0000_000C));

  a_r7_data_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && abort && !$past(acc_is_fetch)) |-> (!abort_fetch && abort_vector == 32'h0000_0010));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(acc_valid)) |-> ((&ce_n) && !abort && ext_addr == '0));

  a_r6_wide_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ce_n) && bus_wide) |-> (ext_addr[1:0] == 2'b00));

  a_r6_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ce_n) && !bus_wide) |-> (ext_addr[0] == 1'b0));
endmodule

bind xrd_top xrd_checks #(.NUM_CS(NUM_CS), .EXT_W(EXT_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_is_fetch (acc_is_fetch),
  .ce_n         (ce_n),
  .ext_addr     (ext_addr),
  .bus_wide     (bus_wide),
  .abort        (abort),
  .abort_fetch  (abort_fetch),
  .abort_vector (abort_vector)
);

// File: tb/tb_xrd_top.sv
module tb_xrd_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_enable, reg_write;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        boot_internal, acc_valid, acc_is_fetch;
  logic [31:0] acc_addr;
  logic [3:0]  ce_n;
  logic [23:0] ext_addr;
  logic        bus_wide, abort, abort_fetch;
  logic [31:0] abort_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  xrd_top dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_enable(reg_enable), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .boot_internal(boot_internal), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_is_fetch(acc_is_fetch),
    .ce_n(ce_n), .ext_addr(ext_addr), .bus_wide(bus_wide),
    .abort(abort), .abort_fetch(abort_fetch), .abort_vector(abort_vector)
  );

  // {addr, fetch, boot, exp_ce_n, exp_abort, exp_wide, exp_ext}
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0012_3457, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b0, 24'h12_3456}, // R6 narrow
    {32'h1000_5678, 1'b1, 1'b0, 4'b1101, 1'b0, 1'b1, 24'h00_5678}, // R5 R1 over R2
    {32'h100F_FFFF, 1'b0, 1'b0, 4'b1101, 1'b0, 1'b1, 24'h0F_FFFC}, // R6 wide top
    {32'h1020_0005, 1'b0, 1'b0, 4'b1011, 1'b0, 1'b0, 24'h20_0004}, // R3 R2 only
    {32'h2000_3010, 1'b0, 1'b0, 4'b1111, 1'b1, 1'b0, 24'h00_0000}, // R10 disabled
    {32'h8000_0000, 1'b1, 1'b0, 4'b1111, 1'b1, 1'b0, 24'h00_0000}, // R7 fetch
    {32'h0100_0000, 1'b0, 1'b0, 4'b1111, 1'b1, 1'b0, 24'h00_0000}, // R3 past page
    {32'h0000_0100, 1'b1, 1'b1, 4'b1111, 1'b1, 1'b0, 24'h00_0000}, // R8 boot blocks 0
    {32'h1000_0010, 1'b0, 1'b1, 4'b1101, 1'b0, 1'b1, 24'h00_0010}  // R8 others fine
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d, input bit do_enable);
    @(negedge clk);
    reg_sel = 1'b1; reg_write = 1'b1; reg_enable = 1'b0;
    reg_addr = 4'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_enable = do_enable;
    @(negedge clk);
    reg_sel = 1'b0; reg_enable = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(idx * 4);
    #1 d = reg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic f, input logic b);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_is_fetch = f; boot_internal = b;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [3:0] ce, input logic w,
                            input logic [23:0] ea);
    chk(req, 64'(ce_n), 64'(ce));
    chk(req, 64'(abort), 64'(0));
    chk(req, 64'(bus_wide), 64'(w));
    chk(req, 64'(ext_addr), 64'(ea));
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0;
    reg_sel = 0; reg_enable = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    boot_internal = 0; acc_valid = 0; acc_addr = 0; acc_is_fetch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 ce_n", 64'(ce_n), 64'hF);
    chk("R1 abort", 64'(abort), 64'h0);
    reg_rd(0, rd); chk("R1 reg0", 64'(rd), 64'h0000_00C1);
    for (int i = 1; i < 4; i++) begin
      reg_rd(i, rd); chk("R1 regN", 64'(rd), 64'h0);
    end

    // R2 register writes
    reg_wr(1, 32'h1000_0083, 1'b1);
    reg_rd(1, rd); chk("R2 reg1", 64'(rd), 64'h1000_0083);
    reg_wr(2, 32'h1000_00C1, 1'b1);
    reg_wr(3, 32'h2000_3F0A, 1'b0);
    reg_rd(3, rd); chk("R2 no enable no write", 64'(rd), 64'h0);
    reg_wr(3, 32'h2000_3F0A, 1'b1);
    reg_rd(3, rd); chk("R2 reserved bits dropped", 64'(rd), 64'h2000_3002);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [63:0] e;
      logic [31:0] evec;
      e = VEC[v];
      access(e[63:32], e[31], e[30]);
      evec = e[25] ? (e[31] ? 32'h0000_000C : 32'h0000_0010) : 32'h0;
      chk("R4 R5 ce_n", 64'(ce_n), 64'(e[29:26]));
      chk("R7 abort", 64'(abort), 64'(e[25]));
      chk("R7 abort_fetch", 64'(abort_fetch), 64'(e[25] & e[31]));
      chk("R7 vector", 64'(abort_vector), 64'(evec));
      if (!e[25]) begin
        chk("R6 wide", 64'(bus_wide), 64'(e[24]));
        chk("R6 ext_addr", 64'(ext_addr), 64'(e[23:0]));
      end
    end

    // R10 enabling region 3, smallest page
    reg_wr(3, 32'h2000_3003, 1'b1);
    access(32'h2000_3FFF, 1'b0, 1'b0);
    expect_hit("R10 enabled small page", 4'b0111, 1'b1, 24'h00_0FFC);
    access(32'h2000_4000, 1'b0, 1'b0);
    chk("R3 just past 4K page", 64'(abort), 64'h1);

    // R3 base bits below the page size ignored
    reg_wr(1, 32'h1005_5083, 1'b1);
    reg_rd(1, rd); chk("R2 stored low base bits", 64'(rd), 64'h1005_5083);
    access(32'h1000_0020, 1'b0, 1'b0);
    expect_hit("R3 base low bits ignored", 4'b1101, 1'b1, 24'h00_0020);

    // R9 idle cycle after an access
    @(negedge clk);
    chk("R9 idle ce_n", 64'(ce_n), 64'hF);
    chk("R9 idle abort", 64'(abort), 64'h0);
    chk("R9 idle ext", 64'(ext_addr), 64'h0);

    // R8 boot low again restores region 0
    access(32'h0000_0102, 1'b1, 1'b0);
    expect_hit("R8 boot low region0", 4'b1110, 1'b0, 24'h00_0102);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule